// File: doc/BRIEF.md
# GPIO Bank with Grouped Interrupt Causes

A bank of up to 32 general-purpose lines behind a plain word-wide register bus. For each line, software can set a drive value, choose input or output, make an output blink and invert how the input is seen. Incoming pin levels pass through a two-stage synchronizer and are then XORed with the polarity setting. The result is the value software reads back as the input state.

The corrected input feeds two interrupt sources. The level source is the corrected input gated by a level mask, and it holds no state. The edge source records each low-to-high step of the corrected input in a sticky cause register, gated by an edge mask. Software acknowledges edges by writing zeros to the cause bits it wants cleared. The masked level and edge terms are ORed together per line. The lines are then reduced in groups of eight, and each group drives its own interrupt output.

Top module: `gpio_irq_bank`

## Requirements
- R1: After reset the drive value, blink enables, polarity, edge cause, edge mask and level mask all read 0. The direction register reads all ones, so `pin_oe` is 0 and every `irq_grp` bit is 0.
- R2: Byte offsets select the registers as follows: 0x00 drive value, 0x04 direction, 0x08 blink enable, 0x0C polarity, 0x10 input state (read only, writes have no effect), 0x14 edge cause, 0x18 edge mask, 0x1C level mask. The writable registers read back what was last written, and any other offset reads 0.
- R3: A direction bit of 1 makes the line an input (`pin_oe` bit 0). A direction bit of 0 makes it an output (`pin_oe` bit 1) driven from the drive-value bit.
- R4: The input state at 0x10 equals the pin XOR its polarity bit, and it is readable after two clock edges.
- R5: The level interrupt term of a line is its input state AND its level-mask bit. It is not latched and drops as soon as the input drops.
- R6: On the clock edge after the input state of a line goes from 0 to 1, that line's edge-cause bit becomes 1. The bit stays 1 after the input falls again.
- R7: A write to the edge cause clears every bit written as 0 and keeps every bit written as 1.
- R8: If an edge sets a cause bit in the same cycle as a write that would clear it, the bit ends up as 1.
- R9: `irq_grp[g]` is the OR over lines 8g to 8g+7 of (level term OR (cause AND edge mask)). Unmasked causes do not raise it.
- R10: An output line with its blink bit set toggles once every BLINK_HALF cycles from a shared divider. An output line with its blink bit clear follows its drive-value bit.
- R11: With a line's polarity bit set, a falling pin is recorded as an edge cause.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_we | input | 1 | Write strobe, committed at the rising edge |
| bus_addr | input | 6 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| pin_in | input | 32 | Asynchronous pin levels |
| pin_out | output | 32 | Pin drive values |
| pin_oe | output | 32 | Pin output enables, 1 = drive |
| irq_grp | output | 4 | One interrupt per group of eight lines |

## Verification
A vector table steps the level path through several combinations of polarity, level mask and pin state:
- all pins low with every mask open;
- one pin inside and then outside its group's mask;
- full inversion, where every line reads high;
- a partial inversion;
- one line in each of two groups;
- a final all-low step that shows the level path does not latch.

Together these separate a wrong XOR, a wrong mask, a wrong group split and any stray latching.

Directed sequences cover the edge path:
- two lines rising, only one of them edge-masked;
- acknowledging a single line by writing all ones except that bit;
- a rise that lands in the same cycle as a clearing write;
- a falling pin seen through an inverted polarity bit.

Register readback, output enables and the blink period are checked at the ports.

// File: rtl/gpio_bank_pkg.sv
// Package: register offsets shared by the GPIO bank and its checker.
package gpio_bank_pkg;
    localparam int unsigned OFF_DRIVE  = 'h00;
    localparam int unsigned OFF_DIR    = 'h04;
    localparam int unsigned OFF_BLINK  = 'h08;
    localparam int unsigned OFF_POL    = 'h0C;
    localparam int unsigned OFF_STATE  = 'h10;
    localparam int unsigned OFF_CAUSE  = 'h14;
    localparam int unsigned OFF_EMASK  = 'h18;
    localparam int unsigned OFF_LMASK  = 'h1C;
endpackage

// File: rtl/gpio_sync2.sv
// Two-flop synchronizer for a vector of independent asynchronous inputs.
// Assumes each bit is treated separately; no bus coherency is implied.
module gpio_sync2 #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] meta;

    // Two register stages; both clear on reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            meta <= '0;
            q    <= '0;
        end else begin
            meta <= d;
            q    <= meta;
        end
    end
endmodule

// File: rtl/gpio_blink_div.sv
// Free-running divider producing a square wave that flips every
// HALF_PERIOD cycles. Shared by all blinking lines. Assumes HALF_PERIOD >= 1.
module gpio_blink_div #(
    parameter int HALF_PERIOD = 1024
) (
    input  logic clk,
    input  logic rst_n,
    output logic phase
);
    localparam int CW = (HALF_PERIOD > 1) ? $clog2(HALF_PERIOD) : 1;
    localparam logic [CW-1:0] LAST = CW'(HALF_PERIOD - 1);

    logic [CW-1:0] cnt;

    // Count to the half period, then wrap and flip the phase.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt   <= '0;
            phase <= 1'b0;
        end else if (cnt == LAST) begin
            cnt   <= '0;
            phase <= ~phase;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end
endmodule

// File: rtl/gpio_edge_cause.sv
// Sticky rising-edge cause register. A bit is set one edge after its input
// goes 0 to 1. A clearing write drops the bits written as 0. A set in the
// same cycle as a clear wins.
module gpio_edge_cause #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] level,
    input  logic         clr_we,
    input  logic [W-1:0] clr_keep,
    output logic [W-1:0] cause
);
    logic [W-1:0] level_d;
    logic [W-1:0] rise;
    logic [W-1:0] kept;

    // Detect 0-to-1 steps and select which bits survive a write.
    always_comb begin
        rise = level & ~level_d;
        kept = clr_we ? (cause & clr_keep) : cause;
    end

    // Remember the previous level and update the sticky causes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            level_d <= '0;
            cause   <= '0;
        end else begin
            level_d <= level;
            cause   <= kept | rise;
        end
    end
endmodule

// File: rtl/gpio_irq_bank.sv
// GPIO bank top: register file, pin drive with blink, synchronized and
// polarity-corrected inputs, and level/edge interrupt causes merged per
// group of GROUP_W lines. Assumes N_LINES <= DATA_W and reads are
// combinational on bus_addr.
module gpio_irq_bank
    import gpio_bank_pkg::*;
#(
    parameter int N_LINES     = 32,
    parameter int DATA_W      = 32,
    parameter int ADDR_W      = 6,
    parameter int GROUP_W     = 8,
    parameter int BLINK_HALF  = 1024,
    localparam int N_GROUPS   = (N_LINES + GROUP_W - 1) / GROUP_W
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                bus_we,
    input  logic [ADDR_W-1:0]   bus_addr,
    input  logic [DATA_W-1:0]   bus_wdata,
    output logic [DATA_W-1:0]   bus_rdata,
    input  logic [N_LINES-1:0]  pin_in,
    output logic [N_LINES-1:0]  pin_out,
    output logic [N_LINES-1:0]  pin_oe,
    output logic [N_GROUPS-1:0] irq_grp
);
    localparam int PAD_W = N_GROUPS * GROUP_W;

    logic [N_LINES-1:0] drive_q, dir_q, blink_q, pol_q, emask_q, lmask_q;
    logic [N_LINES-1:0] pin_sync, state_w, cause_q, pend_w;
    logic [N_LINES-1:0] wdata_n;
    logic [PAD_W-1:0]   pend_pad;
    logic               cause_we;
    logic               blink_phase;

    assign wdata_n  = bus_wdata[N_LINES-1:0];
    assign cause_we = bus_we && (bus_addr == ADDR_W'(OFF_CAUSE));

    // Configuration register writes; direction resets to all inputs.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            drive_q <= '0;
            dir_q   <= '1;
            blink_q <= '0;
            pol_q   <= '0;
            emask_q <= '0;
            lmask_q <= '0;
        end else if (bus_we) begin
            case (bus_addr)
                ADDR_W'(OFF_DRIVE): drive_q <= wdata_n;
                ADDR_W'(OFF_DIR):   dir_q   <= wdata_n;
                ADDR_W'(OFF_BLINK): blink_q <= wdata_n;
                ADDR_W'(OFF_POL):   pol_q   <= wdata_n;
                ADDR_W'(OFF_EMASK): emask_q <= wdata_n;
                ADDR_W'(OFF_LMASK): lmask_q <= wdata_n;
                default: ;
            endcase
        end
    end

    gpio_sync2 #(.W(N_LINES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (pin_in),
        .q     (pin_sync)
    );

    assign state_w = pin_sync ^ pol_q;

    gpio_edge_cause #(.W(N_LINES)) u_cause (
        .clk      (clk),
        .rst_n    (rst_n),
        .level    (state_w),
        .clr_we   (cause_we),
        .clr_keep (wdata_n),
        .cause    (cause_q)
    );

    gpio_blink_div #(.HALF_PERIOD(BLINK_HALF)) u_blink (
        .clk   (clk),
        .rst_n (rst_n),
        .phase (blink_phase)
    );

    // Pin drive: blinking lines follow the divider, others the drive bit.
    always_comb begin
        for (int i = 0; i < N_LINES; i++) begin
            pin_out[i] = blink_q[i] ? blink_phase : drive_q[i];
        end
        pin_oe = ~dir_q;
    end

    // Per-line pending term from both interrupt sources.
    assign pend_w   = (state_w & lmask_q) | (cause_q & emask_q);
    assign pend_pad = PAD_W'(pend_w);

    genvar g;
    generate
        for (g = 0; g < N_GROUPS; g++) begin : g_grp
            assign irq_grp[g] = |pend_pad[g*GROUP_W +: GROUP_W];
        end
    endgenerate

    // Read multiplexer; unmapped offsets return zero.
    always_comb begin
        bus_rdata = '0;
        case (bus_addr)
            ADDR_W'(OFF_DRIVE): bus_rdata = DATA_W'(drive_q);
            ADDR_W'(OFF_DIR):   bus_rdata = DATA_W'(dir_q);
            ADDR_W'(OFF_BLINK): bus_rdata = DATA_W'(blink_q);
            ADDR_W'(OFF_POL):   bus_rdata = DATA_W'(pol_q);
            ADDR_W'(OFF_STATE): bus_rdata = DATA_W'(state_w);
            ADDR_W'(OFF_CAUSE): bus_rdata = DATA_W'(cause_q);
            ADDR_W'(OFF_EMASK): bus_rdata = DATA_W'(emask_q);
            ADDR_W'(OFF_LMASK): bus_rdata = DATA_W'(lmask_q);
            default: bus_rdata = '0;
        endcase
    end
endmodule

// File: rtl/gpio_irq_bank_chk.sv
// Assertion checker for gpio_irq_bank, attached by bind below.
module gpio_irq_bank_chk
    import gpio_bank_pkg::*;
#(
    parameter int N_LINES  = 32,
    parameter int ADDR_W   = 6,
    parameter int N_GROUPS = 4
) (
    input logic                clk,
    input logic                rst_n,
    input logic                bus_we,
    input logic [ADDR_W-1:0]   bus_addr,
    input logic [N_LINES-1:0]  drive_q,
    input logic [N_LINES-1:0]  blink_q,
    input logic [N_LINES-1:0]  emask_q,
    input logic [N_LINES-1:0]  lmask_q,
    input logic [N_LINES-1:0]  cause_q,
    input logic [N_LINES-1:0]  state_w,
    input logic [N_LINES-1:0]  pin_out,
    input logic [N_GROUPS-1:0] irq_grp
);
    // R9: with both masks closed no group interrupt can be raised.
    a_r9_masks_closed_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (emask_q == '0 && lmask_q == '0) |-> (irq_grp == '0));

    // R6: without a cause write, no set bit is lost.
    a_r6_cause_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_we && bus_addr == ADDR_W'(OFF_CAUSE)) |=>
            ((cause_q & $past(cause_q)) == $past(cause_q)));

    // R6: a newly set cause bit needs its input state high one cycle earlier.
    a_r6_cause_from_high: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((cause_q & ~$past(cause_q) & ~$past(state_w)) == '0));

    // R10: a line with blink disabled shows its drive bit.
    a_r10_static_drive: assert property (@(posedge clk) disable iff (!rst_n)
        ((pin_out & ~blink_q) == (drive_q & ~blink_q)));
endmodule

bind gpio_irq_bank gpio_irq_bank_chk #(
    .N_LINES  (N_LINES),
    .ADDR_W   (ADDR_W),
    .N_GROUPS (N_GROUPS)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .bus_we   (bus_we),
    .bus_addr (bus_addr),
    .drive_q  (drive_q),
    .blink_q  (blink_q),
    .emask_q  (emask_q),
    .lmask_q  (lmask_q),
    .cause_q  (cause_q),
    .state_w  (state_w),
    .pin_out  (pin_out),
    .irq_grp  (irq_grp)
);

// File: tb/tb_gpio_irq_bank.sv
module tb_gpio_irq_bank;
    localparam int HALF = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_we = 1'b0;
    logic [5:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [31:0] pin_in = '0;
    logic [31:0] pin_out, pin_oe;
    logic [3:0]  irq_grp;

    int errors = 0;
    int checks = 0;
    int cycles = 0;

    gpio_irq_bank #(.BLINK_HALF(HALF)) dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_we    (bus_we),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .pin_in    (pin_in),
        .pin_out   (pin_out),
        .pin_oe    (pin_oe),
        .irq_grp   (irq_grp)
    );

    always #4 clk = ~clk;

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 20000) begin
            errors = errors + 1;
            $display("FAIL watchdog: run did not finish");
            $display("Result: errors=%0d of %0d checks", errors, checks + 1);
            $finish;
        end
    end

    typedef struct packed {
        logic [31:0] pol;
        logic [31:0] lmask;
        logic [31:0] pins;
        logic [31:0] state;
        logic [3:0]  irq;
    } vec_t;

    localparam vec_t VECS [7] = '{
        '{32'h0000_0000, 32'hFFFF_FFFF, 32'h0000_0000, 32'h0000_0000, 4'b0000},
        '{32'h0000_0000, 32'h0000_00FF, 32'h0000_0001, 32'h0000_0001, 4'b0001},
        '{32'h0000_0000, 32'h0000_FF00, 32'h0000_0001, 32'h0000_0001, 4'b0000},
        '{32'hFFFF_FFFF, 32'hFF00_0000, 32'h0000_0000, 32'hFFFF_FFFF, 4'b1000},
        '{32'h00FF_0000, 32'h00FF_0000, 32'h0001_0000, 32'h00FE_0000, 4'b0100},
        '{32'h0000_0000, 32'h8080_8080, 32'h8000_8000, 32'h8000_8000, 4'b1010},
        '{32'h0000_0000, 32'h8080_8080, 32'h0000_0000, 32'h0000_0000, 4'b0000}
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks = checks + 1;
        if (act !== exp) begin
            errors = errors + 1;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [5:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic rd(input logic [5:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_we = 1'b0; bus_addr = a;
        #1 d = bus_rdata;
    endtask

    task automatic pins(input logic [31:0] v);
        @(negedge clk);
        pin_in = v;
    endtask

    task automatic settle(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        logic [31:0] v;
        int toggles;
        logic prev;
        logic bad_static;

        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state
        #1;
        check("R1 pin_oe", pin_oe, 32'h0);
        check("R1 irq", {28'h0, irq_grp}, 32'h0);
        rd(6'h04, v); check("R1 dir", v, 32'hFFFF_FFFF);
        rd(6'h00, v); check("R1 drive", v, 32'h0);
        rd(6'h14, v); check("R1 cause", v, 32'h0);
        rd(6'h18, v); check("R1 emask", v, 32'h0);
        rd(6'h1C, v); check("R1 lmask", v, 32'h0);

        // R4 R5 R9: level path vector table
        for (int k = 0; k < 7; k++) begin
            wr(6'h0C, VECS[k].pol);
            wr(6'h1C, VECS[k].lmask);
            pins(VECS[k].pins);
            settle(3);
            rd(6'h10, v); check("R4 state", v, VECS[k].state);
            check("R5 R9 level irq", {28'h0, irq_grp}, {28'h0, VECS[k].irq});
        end

        // R7: clear all causes collected above
        wr(6'h0C, 32'h0);
        wr(6'h1C, 32'h0);
        pins(32'h0);
        settle(4);
        wr(6'h14, 32'h0);
        rd(6'h14, v); check("R7 clear all", v, 32'h0);

        // R6 R9: two rising lines, only bit 3 edge-masked
        wr(6'h18, 32'h0000_0008);
        pins(32'h0010_0008);
        settle(3);
        rd(6'h14, v); check("R6 cause set", v, 32'h0010_0008);
        check("R9 edge irq", {28'h0, irq_grp}, 32'h1);
        pins(32'h0);
        settle(3);
        rd(6'h14, v); check("R6 sticky", v, 32'h0010_0008);
        check("R9 sticky irq", {28'h0, irq_grp}, 32'h1);
        wr(6'h14, 32'hFFFF_FFF7);
        rd(6'h14, v); check("R7 ack one", v, 32'h0010_0000);
        check("R9 unmasked cause quiet", {28'h0, irq_grp}, 32'h0);
        wr(6'h14, 32'h0);

        // R8: edge set lands on the same edge as a clearing write
        pins(32'h0000_0200);
        @(negedge clk);
        wr(6'h14, 32'h0);
        rd(6'h14, v); check("R8 set wins", v, 32'h0000_0200);
        wr(6'h14, 32'h0);

        // R11: falling pin seen through polarity
        pins(32'h0000_0220);
        settle(3);
        wr(6'h0C, 32'h0000_0020);
        settle(3);
        wr(6'h14, 32'h0);
        rd(6'h14, v); check("R11 no cause before fall", v, 32'h0);
        pins(32'h0000_0200);
        settle(3);
        rd(6'h14, v); check("R11 falling cause", v, 32'h0000_0020);
        rd(6'h10, v); check("R4 R11 state", v, 32'h0000_0220);

        // R2: readback, read-only state, unmapped offset
        wr(6'h00, 32'hA5A5_A5A5);
        wr(6'h08, 32'h0000_0000);
        wr(6'h1C, 32'h1234_5678);
        rd(6'h00, v); check("R2 drive readback", v, 32'hA5A5_A5A5);
        rd(6'h1C, v); check("R2 lmask readback", v, 32'h1234_5678);
        rd(6'h0C, v); check("R2 pol readback", v, 32'h0000_0020);
        wr(6'h10, 32'hFFFF_FFFF);
        rd(6'h10, v); check("R2 state write ignored", v, 32'h0000_0220);
        rd(6'h20, v); check("R2 unmapped", v, 32'h0);
        wr(6'h1C, 32'h0);

        // R3: direction and drive
        wr(6'h04, 32'hFFFF_0000);
        #1;
        check("R3 oe", pin_oe, 32'h0000_FFFF);
        check("R3 drive", pin_out, 32'hA5A5_A5A5);

        // R10: blink period on line 0, line 1 stays static
        wr(6'h08, 32'h0000_0001);
        toggles = 0;
        bad_static = 1'b0;
        @(negedge clk);
        prev = pin_out[0];
        for (int c = 0; c < 16; c++) begin
            @(negedge clk);
            if (pin_out[0] != prev) toggles++;
            prev = pin_out[0];
            if (pin_out[1] != 1'b0) bad_static = 1'b1;
        end
        check("R10 toggles in 16 cycles", toggles, 4);
        check("R10 static line", {31'h0, bad_static}, 32'h0);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule